// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block is a 16-bit supervision counter that software controls through one 16-bit control word. It counts pulses of one of two clock-enable inputs. In supervisory mode, software must restart the count before the count reaches the selected limit. If the count reaches the limit, the block emits a one-cycle system reset request. In interval mode, the same counter wraps at the limit and sets a sticky interrupt flag each time it does.

Every write to the control word is guarded by a key in the upper byte. A write with the wrong key changes no control state. It raises a reset request at once, so a runaway program that writes the control word at random cannot quietly disable the supervision. A read returns the stored control bits under a fixed read key. The clock selector, the reset controller and the processor sit outside this block.

Top module: `guard_timer`

## Requirements
- R1: After a synchronous reset, the block comes up as follows: `rd_data` reads 0x6900, `irq_flag` and `sys_rst_pulse` are low, and the counter starts at zero. The block is in supervisory mode with all control bits zero: counting, source A, and the longest limit.
- R2: A write whose upper byte is 0x5A is accepted and stores the control bits of the lower byte. The bit positions are: bit 7 hold, bit 4 interval mode, bit 3 count clear, bit 2 source select (1 = `tick_b`), and bits 1:0 limit select. `rd_data` returns 0x69 in bits 15:8 and the stored bits in their write positions. Bits 6, 5 and 3 always read 0.
- R3: A write whose upper byte is anything other than 0x5A leaves the stored control bits unchanged. It drives `sys_rst_pulse` high in the cycle after the write.
- R4: In supervisory mode, counting from zero, the Nth counted tick at limit N drives `sys_rst_pulse` high in the following cycle. The count returns to zero, so the next expiry follows another N ticks. With the default setting N is 32768.
- R5: Limit select values 0, 1, 2 and 3 give limits of 32768, 8192, 512 and 64 ticks. If the count already lies at or beyond a newly chosen shorter limit, the next counted tick expires.
- R6: In interval mode, expiry sets `irq_flag` in the following cycle and raises no reset pulse. `irq_flag` stays set until `irq_clr` is sampled high, and a new expiry takes priority over a clear.
- R7: An accepted write with the count-clear bit set returns the count to zero. The count restarts from zero, so the expiry moves a full limit later.
- R8: While hold is set, the count does not advance and nothing expires. When hold is released, counting resumes from the held value.
- R9: Only the tick input chosen by the source select advances the count. Pulses on the other input have no effect.
- R10: `sys_rst_pulse` is never high for two consecutive cycles. A reset cause that arrives while the pulse is high merges into that pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word: key in 15:8, control bits in 7:0 |
| rd_data | output | 16 | Read key 0x69 in 15:8, stored control bits in 7:0 |
| tick_a | input | 1 | Clock enable, source A |
| tick_b | input | 1 | Clock enable, source B |
| irq_clr | input | 1 | Clears the interval interrupt flag |
| irq_flag | output | 1 | Sticky interval interrupt flag |
| sys_rst_pulse | output | 1 | One-cycle system reset request |

## Verification
The counter is not visible at the ports, so a wrong count shows up only through the timing of expiry. A count that is off by one, clears at the wrong moment, or keeps counting under hold makes `sys_rst_pulse` or `irq_flag` rise one or more cycles away from the expected edge. That error appears no later than the next expiry of the selected limit. For this reason most runs use the 64-tick limit, and one full 32768-tick run is made. A wrong stored control bit shows up at `rd_data` in the cycle after the write. A key comparison that accepts a bad key shows up as a missing reset pulse one cycle after the write.

// File: rtl/guard_pkg.sv
package guard_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = 8;

    // Control byte bit positions (software-visible layout)
    localparam int POS_HOLD = 7;
    localparam int POS_MODE = 4;
    localparam int POS_CLR  = 3;
    localparam int POS_SRC  = 2;
    localparam int POS_SPAN = 0;
    localparam int SPAN_W   = 2;
    localparam int SPAN_N   = 1 << SPAN_W;

    typedef enum logic [SPAN_W-1:0] {
        SPAN_LONG  = 2'd0,
        SPAN_MID   = 2'd1,
        SPAN_SHORT = 2'd2,
        SPAN_TINY  = 2'd3
    } span_e;

    typedef struct packed {
        logic  hold;
        logic  interval;
        logic  src_b;
        span_e span;
    } guard_cfg_t;

    localparam guard_cfg_t CFG_RESET = '{hold: 1'b0, interval: 1'b0,
                                         src_b: 1'b0, span: SPAN_LONG};

    // Decode the lower byte of a write into stored control bits
    function automatic guard_cfg_t unpack_cfg(input logic [BYTE_W-1:0] b);
        guard_cfg_t c;
        c.hold     = b[POS_HOLD];
        c.interval = b[POS_MODE];
        c.src_b    = b[POS_SRC];
        c.span     = span_e'(b[POS_SPAN +: SPAN_W]);
        return c;
    endfunction

    // Rebuild the readable control byte; reserved and strobe bits read zero
    function automatic logic [BYTE_W-1:0] pack_cfg(input guard_cfg_t c);
        logic [BYTE_W-1:0] b;
        b = '0;
        b[POS_HOLD] = c.hold;
        b[POS_MODE] = c.interval;
        b[POS_SRC]  = c.src_b;
        b[POS_SPAN +: SPAN_W] = c.span;
        return b;
    endfunction

    // Terminal value (limit minus one) for a power-of-two limit
    function automatic logic [WORD_W-1:0] term_value(input int exp2);
        logic [WORD_W:0] wide;
        wide = (WORD_W+1)'(1) << exp2;
        return WORD_W'(wide - 1'b1);
    endfunction

endpackage

// File: rtl/guard_ctrl.sv
module guard_ctrl
    import guard_pkg::*;
#(
    parameter logic [BYTE_W-1:0] WR_KEY = 8'h5A,
    parameter logic [BYTE_W-1:0] RD_KEY = 8'h69
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output guard_cfg_t        cfg,
    output logic              clr_req,
    output logic              key_fault,
    output logic [WORD_W-1:0] rd_data
);

    logic key_match;
    logic accept;

    assign key_match = (wr_data[WORD_W-1 -: BYTE_W] == WR_KEY);
    assign accept    = wr_en && key_match;
    assign key_fault = wr_en && !key_match;
    assign clr_req   = accept && wr_data[POS_CLR];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (accept) begin
            cfg <= unpack_cfg(wr_data[BYTE_W-1:0]);
        end
    end

    assign rd_data = {RD_KEY, pack_cfg(cfg)};

    // A keyless write must not alter stored control bits
    p_bad_key_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        key_fault |=> $stable(cfg));

    // An accepted write lands in the stored control bits
    p_good_key_stored_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !key_fault) |=> (cfg == unpack_cfg($past(wr_data[BYTE_W-1:0]))));

endmodule

// File: rtl/guard_counter.sv
module guard_counter
    import guard_pkg::*;
#(
    parameter int EXP_LONG  = 15,
    parameter int EXP_MID   = 13,
    parameter int EXP_SHORT = 9,
    parameter int EXP_TINY  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_a,
    input  logic              tick_b,
    input  guard_cfg_t        cfg,
    input  logic              clr_req,
    output logic              expire
);

    localparam int EXPS [SPAN_N] = '{EXP_LONG, EXP_MID, EXP_SHORT, EXP_TINY};

    logic [WORD_W-1:0] term [SPAN_N];
    logic [WORD_W-1:0] count;
    logic [WORD_W-1:0] term_sel;
    logic              tick_sel;
    logic              step;

    for (genvar g = 0; g < SPAN_N; g++) begin : g_term
        assign term[g] = term_value(EXPS[g]);
    end

    assign term_sel = term[cfg.span];
    assign tick_sel = cfg.src_b ? tick_b : tick_a;
    assign step     = tick_sel && !cfg.hold;
    assign expire   = step && (count >= term_sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (clr_req || expire) begin
            count <= '0;
        end else if (step) begin
            count <= count + 1'b1;
        end
    end

    // Hold freezes the count unless software clears it
    p_hold_freeze_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg.hold && !clr_req) |=> $stable(count));

    // Expiry always restarts the count from zero
    p_expire_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        expire |=> (count == '0));

    // A software clear restarts the count
    p_clear_restart_r7: assert property (@(posedge clk) disable iff (rst)
        clr_req |=> (count == '0));

    // The unselected tick never advances the count
    p_src_select_r9: assert property (@(posedge clk) disable iff (rst)
        (!tick_sel && !clr_req) |=> $stable(count));

endmodule

// File: rtl/guard_action.sv
module guard_action
    import guard_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic interval,
    input  logic key_fault,
    input  logic irq_clr,
    output logic sys_rst_pulse,
    output logic irq_flag
);

    logic rst_cause;
    logic irq_set;

    assign rst_cause = key_fault || (expire && !interval);
    assign irq_set   = expire && interval;

    always_ff @(posedge clk) begin
        if (rst) begin
            sys_rst_pulse <= 1'b0;
            irq_flag      <= 1'b0;
        end else begin
            sys_rst_pulse <= rst_cause && !sys_rst_pulse;
            if (irq_set) begin
                irq_flag <= 1'b1;
            end else if (irq_clr) begin
                irq_flag <= 1'b0;
            end
        end
    end

    p_pulse_single_r10: assert property (@(posedge clk) disable iff (rst)
        sys_rst_pulse |=> !sys_rst_pulse);

    p_bad_key_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        (key_fault && !sys_rst_pulse) |=> sys_rst_pulse);

    p_irq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (irq_flag && !irq_clr) |=> irq_flag);

    p_interval_no_reset_r6: assert property (@(posedge clk) disable iff (rst)
        (expire && interval && !key_fault) |=> (irq_flag && !sys_rst_pulse));

endmodule

// File: rtl/guard_timer.sv
module guard_timer
    import guard_pkg::*;
#(
    parameter logic [7:0] WR_KEY    = 8'h5A,
    parameter logic [7:0] RD_KEY    = 8'h69,
    parameter int         EXP_LONG  = 15,
    parameter int         EXP_MID   = 13,
    parameter int         EXP_SHORT = 9,
    parameter int         EXP_TINY  = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        tick_a,
    input  logic        tick_b,
    input  logic        irq_clr,
    output logic        irq_flag,
    output logic        sys_rst_pulse
);

    guard_cfg_t cfg;
    logic       clr_req;
    logic       key_fault;
    logic       expire;

    guard_ctrl #(
        .WR_KEY (WR_KEY),
        .RD_KEY (RD_KEY)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .cfg       (cfg),
        .clr_req   (clr_req),
        .key_fault (key_fault),
        .rd_data   (rd_data)
    );

    guard_counter #(
        .EXP_LONG  (EXP_LONG),
        .EXP_MID   (EXP_MID),
        .EXP_SHORT (EXP_SHORT),
        .EXP_TINY  (EXP_TINY)
    ) u_count (
        .clk     (clk),
        .rst     (rst),
        .tick_a  (tick_a),
        .tick_b  (tick_b),
        .cfg     (cfg),
        .clr_req (clr_req),
        .expire  (expire)
    );

    guard_action u_act (
        .clk           (clk),
        .rst           (rst),
        .expire        (expire),
        .interval      (cfg.interval),
        .key_fault     (key_fault),
        .irq_clr       (irq_clr),
        .sys_rst_pulse (sys_rst_pulse),
        .irq_flag      (irq_flag)
    );

    // Reset state of the externally visible outputs
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (!irq_flag && !sys_rst_pulse));

endmodule

// File: tb/guard_timer_test.sv
module guard_timer_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        tick_a = 1'b0;
    logic        tick_b = 1'b0;
    logic        irq_clr = 1'b0;
    logic [15:0] rd_data;
    logic        irq_flag;
    logic        sys_rst_pulse;

    int checks = 0;
    int errors = 0;

    // Requirement-level model state
    logic       m_hold, m_int, m_src;
    logic [1:0] m_span;
    int         m_cnt;
    logic       m_pulse, m_irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    guard_timer uut (
        .clk           (clk),
        .rst           (rst),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .rd_data       (rd_data),
        .tick_a        (tick_a),
        .tick_b        (tick_b),
        .irq_clr       (irq_clr),
        .irq_flag      (irq_flag),
        .sys_rst_pulse (sys_rst_pulse)
    );

    function automatic int limit_of(input logic [1:0] s);
        case (s)
            2'd0:    return 32768;
            2'd1:    return 8192;
            2'd2:    return 512;
            default: return 64;
        endcase
    endfunction

    function automatic logic [15:0] exp_read();
        return {8'h69, m_hold, 2'b00, m_int, 1'b0, m_src, m_span};
    endfunction

    task automatic chk(input string req, input string what, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, expv, $time);
        end
    endtask

    task automatic model_step();
        logic bad, good, tick, ex, nxt_pulse, nxt_irq;
        if (rst) begin
            m_hold = 0; m_int = 0; m_src = 0; m_span = 0;
            m_cnt = 0; m_pulse = 0; m_irq = 0;
        end else begin
            bad  = wr_en && (wr_data[15:8] != 8'h5A);
            good = wr_en && !bad;
            tick = m_src ? tick_b : tick_a;
            ex   = tick && !m_hold && (m_cnt >= limit_of(m_span) - 1);
            nxt_pulse = (bad || (ex && !m_int)) && !m_pulse;
            nxt_irq   = (ex && m_int) ? 1'b1 : (irq_clr ? 1'b0 : m_irq);
            if (good && wr_data[3])      m_cnt = 0;
            else if (ex)                 m_cnt = 0;
            else if (tick && !m_hold)    m_cnt = m_cnt + 1;
            if (good) begin
                m_hold = wr_data[7]; m_int = wr_data[4];
                m_src  = wr_data[2]; m_span = wr_data[1:0];
            end
            m_pulse = nxt_pulse;
            m_irq   = nxt_irq;
        end
    endtask

    // One clock: edge, model update, compare at the falling edge
    task automatic cycle(input string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        chk(req, "rd_data", rd_data, exp_read());
        chk(req, "irq_flag", irq_flag, m_irq);
        chk(req, "sys_rst_pulse", sys_rst_pulse, m_pulse);
        wr_en   = 1'b0;
        irq_clr = 1'b0;
    endtask

    task automatic write_word(input logic [15:0] d, input string req);
        wr_en = 1'b1;
        wr_data = d;
        cycle(req);
    endtask

    task automatic run(input int n, input string req);
        for (int i = 0; i < n; i++) cycle(req);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual still running, expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int first_pulse;
        void'($urandom(32'd2024));
        @(negedge clk);
        rst = 1'b1;
        cycle("R1");
        cycle("R1");
        chk("R1", "reset read", rd_data, 16'h6900);
        rst = 1'b0;

        // R4: full-length supervisory expiry on tick A every cycle
        tick_a = 1'b1;
        first_pulse = 0;
        for (int i = 1; i <= 32770; i++) begin
            cycle("R4");
            if (sys_rst_pulse && first_pulse == 0) first_pulse = i;
        end
        chk("R4", "cycles to first expiry", first_pulse, 32768);

        // R2: stored bits and read layout
        write_word(16'h5A13, "R2");
        chk("R2", "read after write", rd_data, 16'h6913);
        write_word(16'h5A7F, "R2");
        chk("R2", "reserved bits read zero", rd_data, 16'h6917);

        // R3: bad key leaves bits and pulses next cycle; R10 single pulse
        write_word(16'h1200, "R3");
        chk("R3", "bad key pulse", sys_rst_pulse, 1);
        chk("R3", "bad key keeps bits", rd_data, 16'h6917);
        cycle("R10");
        chk("R10", "pulse one cycle", sys_rst_pulse, 0);

        // R6 and R5: interval mode, tiny limit, source A
        write_word(16'h5A1B, "R6");
        first_pulse = 0;
        for (int i = 1; i <= 70; i++) begin
            cycle("R5");
            if (irq_flag && first_pulse == 0) first_pulse = i;
        end
        chk("R5", "64-tick interval", first_pulse, 64);
        chk("R6", "flag sticky", irq_flag, 1);
        irq_clr = 1'b1;
        cycle("R6");
        chk("R6", "flag cleared", irq_flag, 0);

        // R7: clear restarts count before expiry in supervisory mode
        write_word(16'h5A0B, "R7");
        run(60, "R7");
        write_word(16'h5A0B, "R7");
        run(60, "R7");
        chk("R7", "no expiry after restart", sys_rst_pulse, 0);
        run(5, "R7");

        // R8: hold freezes, release resumes
        write_word(16'h5A8B, "R8");
        run(200, "R8");
        chk("R8", "no expiry while held", sys_rst_pulse, 0);
        write_word(16'h5A03, "R8");
        run(10, "R8");

        // R9: source B selected, only tick A toggles
        write_word(16'h5A0F, "R9");
        tick_a = 1'b1; tick_b = 1'b0;
        run(150, "R9");
        chk("R9", "unselected source ignored", sys_rst_pulse, 0);
        tick_b = 1'b1;
        run(70, "R9");

        // R5: shorter limit chosen while count is beyond it
        write_word(16'h5A08, "R5");
        tick_a = 1'b1; tick_b = 1'b0;
        run(100, "R5");
        write_word(16'h5A03, "R5");
        run(3, "R5");

        // Random phase with model comparison
        for (int i = 0; i < 4000; i++) begin
            tick_a  = ($urandom % 4) != 0;
            tick_b  = ($urandom % 2) != 0;
            irq_clr = ($urandom % 12) == 0;
            if (($urandom % 24) == 0) begin
                logic [15:0] d;
                d[15:8] = (($urandom % 5) == 0) ? 8'($urandom) : 8'h5A;
                d[7:0]  = 8'($urandom);
                if (($urandom % 3) != 0) d[1:0] = 2'b11;
                if (($urandom % 2) != 0) d[7] = 1'b0;
                wr_en = 1'b1;
                wr_data = d;
            end
            cycle("R10");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule